// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block sits on the memory side of a double data rate SDRAM. On every rising clock edge it samples the registered command pins, the clock enable, the bank address and the row/column address. It turns the pin pattern into one decoded command and decides whether that command is legal at that moment. It also tracks the open, closed or precharging state of every bank. A mode register holds burst length, burst type, CAS latency and the DLL reset bit.

A command that breaks a rule raises a one-cycle `illegal_o` pulse and leaves all tracked state untouched. The rules cover column access to a closed bank, a burst terminate with no eligible read, a reserved mode code, a mode set while a bank is busy, a command inside the mode-set recovery window, and a read during DLL relock. A precharge aimed at a bank that is already closed or closing is reported as a NOP. All outputs are registered, so each one reflects the command sampled at the previous rising edge.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: After reset, `cmd_o` is DESEL (0) and `illegal_o` is 0. Every bank is idle, `burst_len_o` is 2 and `burst_il_o` is 0 (sequential). `cas_x2_o` is 4 (CAS latency 2), and `dll_rst_o` and `read_lock_o` are 0.
- R2: Pins {cs,ras,cas,we} decode as follows: `cs_ni` high gives DESEL=0, 0111 gives NOP=1, 0011 gives ACT=2, 0101 gives READ=3 or READA=4, and 0100 gives WRITE=5 or WRITEA=6. 0010 gives PRE=7 or PREA=8, 0110 gives TERM=9, 0000 gives MRS=10 (or EMRS=11 when BA=01), and 0001 gives REFA=12 with `cke_i` high or SREF=13 with `cke_i` low. For READ, WRITE and PRE, A10 high selects the second code. The result appears on `cmd_o` one cycle after the sampling edge.
- R3: ACT is legal only on an idle bank, and it makes that bank active. `bank_state_o` holds bits [2b+1:2b] per bank b, coded 00 idle, 01 active and 10 precharging. ACT on any other bank state is illegal.
- R4: READ, READA, WRITE and WRITEA are legal only on an active bank. With A10 high (READA, WRITEA), the bank moves to precharging.
- R5: PRE (A10 low) to an active bank makes it precharging for T_RP cycles (default 2) and then idle. PREA (A10 high) does the same to every active bank. A PRE whose bank is idle or precharging, or a PREA with no active bank, is reported as NOP (1) without `illegal_o`.
- R6: TERM is legal only when the most recent READ/READA/WRITE/WRITEA was a READ with A10 low and no accepted PRE, PREA or TERM has followed it. Otherwise TERM is illegal.
- R7: MRS with BA=00 loads the mode fields. A2..A0 set the burst length (001=2, 010=4, 011=8), A3 the type (1 = interleaved), A6..A4 the CAS latency shown as `cas_x2_o` (010 gives 4, 011 gives 6, 110 gives 5), and A8 gives `dll_rst_o`.
- R8: An MRS with any other burst-length or CAS-latency code is illegal and leaves every mode field unchanged.
- R9: MRS, EMRS, REFA and SREF are legal only when every bank is idle. MRS with BA1 high is illegal.
- R10: After an accepted MRS or EMRS, any command other than DESEL or NOP is illegal for the next T_MRD-1 cycles (default T_MRD 2).
- R11: After an accepted MRS with A8 high, READ and READA are illegal until DLL_LOCK cycles (default 200) after it, and `read_lock_o` is high over that window.
- R12: `illegal_o` is high for exactly the cycle after each illegal command, and that command changes no bank state, mode field or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples commands |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable, separates REFA from SREF |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ADDR_W | Address, A10 is the auto-precharge/all-banks bit |
| cmd_o | output | 4 | Decoded effective command |
| illegal_o | output | 1 | Pulse for a rejected command |
| bank_state_o | output | 2*NUM_BANKS | Per-bank state |
| burst_len_o | output | 4 | Burst length in beats |
| burst_il_o | output | 1 | Interleaved burst type |
| cas_x2_o | output | 3 | CAS latency times two |
| dll_rst_o | output | 1 | Stored DLL reset bit |
| read_lock_o | output | 1 | Reads blocked for DLL relock |

## Verification
`cmd_o`, `illegal_o`, the mode fields and a bank's first state change are all due one cycle after the sampling edge. The precharging state lasts T_RP cycles before reading idle. The mode-set recovery and DLL windows are counted in edges from the accepting edge. The bench drives every command at a falling edge and reads the outputs at the next falling edge, just after the registering edge. It issues exact runs of NOPs to hit the last blocked and first allowed edge of each window. The mode register is swept over every burst-length, type and latency code, and the expected fields and legality are computed in the bench.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,  CMD_NOP  = 4'd1,  CMD_ACT  = 4'd2,  CMD_RD   = 4'd3,
    CMD_RDA   = 4'd4,  CMD_WR   = 4'd5,  CMD_WRA  = 4'd6,  CMD_PRE  = 4'd7,
    CMD_PREA  = 4'd8,  CMD_TERM = 4'd9,  CMD_MRS  = 4'd10, CMD_EMRS = 4'd11,
    CMD_REFA  = 4'd12, CMD_SREF = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'b00,
    BK_ACTIVE = 2'b01,
    BK_PRECH  = 2'b10
  } bank_st_e;

  localparam int unsigned AP_BIT = 10;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned BA_W = 2
) (
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic            cke_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            ap_i,
  output cmd_e            cmd_o
);
  localparam logic [BA_W-1:0] BA_EXT = BA_W'(1);

  always_comb begin
    cmd_o = CMD_NOP;
    if (cs_ni) cmd_o = CMD_DESEL;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111: cmd_o = CMD_NOP;
        3'b011: cmd_o = CMD_ACT;
        3'b101: cmd_o = ap_i ? CMD_RDA : CMD_RD;
        3'b100: cmd_o = ap_i ? CMD_WRA : CMD_WR;
        3'b010: cmd_o = ap_i ? CMD_PREA : CMD_PRE;
        3'b110: cmd_o = CMD_TERM;
        3'b000: cmd_o = (ba_i == BA_EXT) ? CMD_EMRS : CMD_MRS;
        3'b001: cmd_o = cke_i ? CMD_REFA : CMD_SREF;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [3:0]        burst_len_o,
  output logic              burst_il_o,
  output logic [2:0]        cas_x2_o,
  output logic              dll_rst_o
);
  logic [2:0] bl_q, cl_q;
  logic       bt_q, dll_q;
  logic [2:0] bl_in, cl_in;

  assign bl_in   = addr_i[2:0];
  assign cl_in   = addr_i[6:4];
  assign valid_o = (bl_in inside {3'b001, 3'b010, 3'b011}) &&
                   (cl_in inside {3'b010, 3'b011, 3'b110});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_q  <= 3'b001;
      bt_q  <= 1'b0;
      cl_q  <= 3'b010;
      dll_q <= 1'b0;
    end else if (we_i) begin
      bl_q  <= bl_in;
      bt_q  <= addr_i[3];
      cl_q  <= cl_in;
      dll_q <= addr_i[8];
    end
  end

  always_comb begin
    burst_len_o = 4'd1 << bl_q;
    unique case (cl_q)
      3'b011:  cas_x2_o = 3'd6;
      3'b110:  cas_x2_o = 3'd5;
      default: cas_x2_o = 3'd4;
    endcase
  end
  assign burst_il_o = bt_q;
  assign dll_rst_o  = dll_q;

  a_r8_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({bl_q, bt_q, cl_q, dll_q}));
  a_r7_cas_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_x2_o inside {3'd4, 3'd5, 3'd6});
  a_r7_len_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(burst_len_o) && (burst_len_o != 4'd0) && (burst_len_o != 4'd1));
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned T_RP = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     open_i,
  input  logic     close_i,
  output bank_st_e state_o
);
  localparam int unsigned CNT_W = (T_RP > 1) ? $clog2(T_RP) : 1;
  localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(T_RP - 1);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        BK_IDLE: if (open_i) st_q <= BK_ACTIVE;
        BK_ACTIVE: if (close_i) begin
          st_q  <= BK_PRECH;
          cnt_q <= RP_LOAD;
        end
        BK_PRECH: begin
          if (cnt_q == '0) st_q <= BK_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end
  assign state_o = st_q;

  a_r3_open_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BK_ACTIVE && $past(st_q) != BK_ACTIVE) |-> $past(st_q) == BK_IDLE);
  a_r5_prech_from_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BK_PRECH && $past(st_q) != BK_PRECH) |-> $past(st_q) == BK_ACTIVE);
  a_r5_idle_after_prech: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BK_IDLE && $past(st_q) != BK_IDLE) |-> $past(st_q) == BK_PRECH);
  a_r3_no_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != 2'b11);
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned DLL_LOCK  = 200
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cs_ni,
  input  logic                         ras_ni,
  input  logic                         cas_ni,
  input  logic                         we_ni,
  input  logic                         cke_i,
  input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [3:0]                   cmd_o,
  output logic                         illegal_o,
  output logic [2*NUM_BANKS-1:0]       bank_state_o,
  output logic [3:0]                   burst_len_o,
  output logic                         burst_il_o,
  output logic [2:0]                   cas_x2_o,
  output logic                         dll_rst_o,
  output logic                         read_lock_o
);
  localparam int unsigned BA_W  = $clog2(NUM_BANKS);
  localparam int unsigned MRD_W = (T_MRD > 1) ? $clog2(T_MRD) : 1;
  localparam int unsigned DLL_W = $clog2(DLL_LOCK + 1);
  localparam logic [MRD_W-1:0] MRD_LOAD = MRD_W'(T_MRD - 1);
  localparam logic [DLL_W-1:0] DLL_LOAD = DLL_W'(DLL_LOCK - 1);

  cmd_e                 raw_cmd, eff_cmd, cmd_q;
  bank_st_e             bst [NUM_BANKS];
  logic [NUM_BANKS-1:0] b_idle, b_act, open_v, close_v;
  logic                 all_idle, any_act, sel_idle, sel_act;
  logic                 legal, mode_ok, mode_we, mrd_load, dll_load, rd_set, rd_clr;
  logic [MRD_W-1:0]     mrd_q;
  logic [DLL_W-1:0]     dll_q;
  logic                 rd_noap_q, ill_q;

  ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
    .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .cke_i(cke_i), .ba_i(ba_i), .ap_i(addr_i[AP_BIT]), .cmd_o(raw_cmd)
  );

  ddr_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mode_we), .addr_i(addr_i),
    .valid_o(mode_ok), .burst_len_o(burst_len_o), .burst_il_o(burst_il_o),
    .cas_x2_o(cas_x2_o), .dll_rst_o(dll_rst_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_bank_fsm #(.T_RP(T_RP)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .open_i(open_v[b]), .close_i(close_v[b]),
      .state_o(bst[b])
    );
    assign b_idle[b] = (bst[b] == BK_IDLE);
    assign b_act[b]  = (bst[b] == BK_ACTIVE);
    assign bank_state_o[2*b +: 2] = bst[b];
  end

  assign all_idle = &b_idle;
  assign any_act  = |b_act;
  assign sel_idle = b_idle[ba_i];
  assign sel_act  = b_act[ba_i];

  always_comb begin
    legal    = 1'b1;
    eff_cmd  = raw_cmd;
    open_v   = '0;
    close_v  = '0;
    mode_we  = 1'b0;
    mrd_load = 1'b0;
    dll_load = 1'b0;
    rd_set   = 1'b0;
    rd_clr   = 1'b0;
    if (raw_cmd != CMD_DESEL && raw_cmd != CMD_NOP && mrd_q != '0) begin
      legal = 1'b0;
    end else begin
      unique case (raw_cmd)
        CMD_ACT: begin
          legal = sel_idle;
          open_v[ba_i] = 1'b1;
        end
        CMD_RD, CMD_RDA: begin
          legal = sel_act && (dll_q == '0);
          if (raw_cmd == CMD_RD) rd_set = 1'b1;
          else begin
            rd_clr = 1'b1;
            close_v[ba_i] = 1'b1;
          end
        end
        CMD_WR, CMD_WRA: begin
          legal  = sel_act;
          rd_clr = 1'b1;
          if (raw_cmd == CMD_WRA) close_v[ba_i] = 1'b1;
        end
        CMD_PRE: begin
          if (sel_act) begin
            close_v[ba_i] = 1'b1;
            rd_clr = 1'b1;
          end else eff_cmd = CMD_NOP;
        end
        CMD_PREA: begin
          if (any_act) begin
            close_v = b_act;
            rd_clr  = 1'b1;
          end else eff_cmd = CMD_NOP;
        end
        CMD_TERM: begin
          legal  = rd_noap_q;
          rd_clr = 1'b1;
        end
        CMD_MRS: begin
          legal    = all_idle && mode_ok && (ba_i == '0);
          mode_we  = 1'b1;
          mrd_load = 1'b1;
          dll_load = addr_i[8];
        end
        CMD_EMRS: begin
          legal    = all_idle;
          mrd_load = 1'b1;
        end
        CMD_REFA, CMD_SREF: legal = all_idle;
        default: ;
      endcase
    end
    if (!legal) begin
      open_v   = '0;
      close_v  = '0;
      mode_we  = 1'b0;
      mrd_load = 1'b0;
      dll_load = 1'b0;
      rd_set   = 1'b0;
      rd_clr   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= CMD_DESEL;
      ill_q     <= 1'b0;
      mrd_q     <= '0;
      dll_q     <= '0;
      rd_noap_q <= 1'b0;
    end else begin
      cmd_q <= eff_cmd;
      ill_q <= ~legal;
      if (mrd_load) mrd_q <= MRD_LOAD;
      else if (mrd_q != '0) mrd_q <= mrd_q - 1'b1;
      if (dll_load) dll_q <= DLL_LOAD;
      else if (dll_q != '0) dll_q <= dll_q - 1'b1;
      if (rd_set) rd_noap_q <= 1'b1;
      else if (rd_clr) rd_noap_q <= 1'b0;
    end
  end

  assign cmd_o       = cmd_q;
  assign illegal_o   = ill_q;
  assign read_lock_o = (dll_q != '0);

  a_r11_no_read_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && (cmd_o == CMD_RD || cmd_o == CMD_RDA)) |-> $past(dll_q) == '0);
  a_r10_mrd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && cmd_o != CMD_DESEL && cmd_o != CMD_NOP) |-> $past(mrd_q) == '0);
  a_r12_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable({burst_len_o, burst_il_o, cas_x2_o, dll_rst_o}));
  a_r9_mrs_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && cmd_o == CMD_MRS) |-> $past(all_idle));
  a_r5_one_close_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(open_v) && ((open_v & close_v) == '0));
endmodule

// File: tb/ddr_cmd_tracker_tb.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, cke_i = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [12:0] addr_i = '0;
  logic [3:0]  cmd_o;
  logic        illegal_o;
  logic [7:0]  bank_state_o;
  logic [3:0]  burst_len_o;
  logic        burst_il_o;
  logic [2:0]  cas_x2_o;
  logic        dll_rst_o;
  logic        read_lock_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] P_DESEL = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_PRE = 4'b0010,
                         P_TERM = 4'b0110, P_MRS = 4'b0000, P_REF = 4'b0001;
  localparam logic [12:0] A10 = 13'h0400;

  always #2.5 clk_i = ~clk_i;

  ddr_cmd_tracker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .cke_i(cke_i), .ba_i(ba_i), .addr_i(addr_i), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .bank_state_o(bank_state_o), .burst_len_o(burst_len_o),
    .burst_il_o(burst_il_o), .cas_x2_o(cas_x2_o), .dll_rst_o(dll_rst_o),
    .read_lock_o(read_lock_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at falling edge, registered at next rising edge, read at next falling edge
  task automatic issue(input logic [3:0] p, input logic ck, input logic [1:0] b,
                       input logic [12:0] a);
    {cs_ni, ras_ni, cas_ni, we_ni} = p;
    cke_i = ck; ba_i = b; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic expect_cmd(input string tag, input int c, input bit ill);
    chk({tag, " cmd"}, int'(cmd_o), c);
    chk({tag, " illegal"}, int'(illegal_o), int'(ill));
  endtask

  function automatic logic [12:0] mrs_a(input bit dll, input logic [2:0] cl,
                                        input bit bt, input logic [2:0] bl);
    return {4'b0, dll, 1'b0, cl, bt, bl};
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_bl, exp_cas;
    bit exp_il;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 cmd", cmd_o, 0);
    chk("R1 illegal", illegal_o, 0);
    chk("R1 banks", bank_state_o, 0);
    chk("R1 bl", burst_len_o, 2);
    chk("R1 bt", burst_il_o, 0);
    chk("R1 cas", cas_x2_o, 4);
    chk("R1 dll", dll_rst_o, 0);
    chk("R1 lock", read_lock_o, 0);

    // R2 decode
    issue(P_DESEL, 1, 0, 0); expect_cmd("R2 desel", 0, 0);
    issue(P_NOP, 1, 0, 0);   expect_cmd("R2 nop", 1, 0);
    // R4 column access to idle bank
    issue(P_RD, 1, 0, 0);    expect_cmd("R4 rd idle", 3, 1);
    issue(P_NOP, 1, 0, 0);   chk("R12 pulse ends", illegal_o, 0);
    issue(P_WR, 1, 0, A10);  expect_cmd("R4 wra idle", 6, 1);
    // R3 activate every bank
    for (int b = 0; b < 4; b++) begin
      issue(P_ACT, 1, 2'(b), 0);
      expect_cmd("R3 act", 2, 0);
      chk("R3 bank active", bank_state_o[2*b +: 2], 1);
    end
    issue(P_ACT, 1, 0, 0);   expect_cmd("R3 act again", 2, 1);
    chk("R12 banks kept", bank_state_o, 8'h55);
    // R6 burst terminate
    issue(P_TERM, 1, 0, 0);  expect_cmd("R6 term no read", 9, 1);
    issue(P_RD, 1, 1, 0);    expect_cmd("R2 read", 3, 0);
    issue(P_TERM, 1, 0, 0);  expect_cmd("R6 term ok", 9, 0);
    issue(P_TERM, 1, 0, 0);  expect_cmd("R6 term twice", 9, 1);
    issue(P_RD, 1, 1, 0);    expect_cmd("R2 read", 3, 0);
    issue(P_WR, 1, 0, 0);    expect_cmd("R2 write", 5, 0);
    issue(P_TERM, 1, 0, 0);  expect_cmd("R6 term after write", 9, 1);
    issue(P_RD, 1, 1, A10);  expect_cmd("R4 reada", 4, 0);
    chk("R4 reada closes", bank_state_o[3:2], 2);
    issue(P_TERM, 1, 0, 0);  expect_cmd("R6 term after reada", 9, 1);
    chk("R5 prech 2nd cycle", bank_state_o[3:2], 2);
    issue(P_NOP, 1, 0, 0);
    chk("R5 idle after trp", bank_state_o[3:2], 0);
    // R5 precharge corner cases
    issue(P_PRE, 1, 2, 0);   expect_cmd("R5 pre", 7, 0);
    chk("R5 pre closes", bank_state_o[5:4], 2);
    issue(P_PRE, 1, 2, 0);   expect_cmd("R5 pre on prech", 1, 0);
    issue(P_PRE, 1, 1, 0);   expect_cmd("R5 pre on idle", 1, 0);
    // R9 needs all idle
    issue(P_MRS, 1, 0, mrs_a(0, 3'b010, 0, 3'b001)); expect_cmd("R9 mrs busy", 10, 1);
    issue(P_REF, 1, 0, 0);   expect_cmd("R9 refa busy", 12, 1);
    issue(P_PRE, 1, 0, A10); expect_cmd("R5 prea", 8, 0);
    chk("R5 prea banks", bank_state_o, 8'h82);
    issue(P_PRE, 1, 0, A10); expect_cmd("R5 prea none", 1, 0);
    issue(P_NOP, 1, 0, 0);
    chk("R5 all idle", bank_state_o, 0);
    issue(P_REF, 1, 0, 0);   expect_cmd("R9 refa", 12, 0);
    issue(P_REF, 0, 0, 0);   expect_cmd("R9 sref", 13, 0);
    issue(P_MRS, 1, 2, mrs_a(0, 3'b010, 0, 3'b001)); expect_cmd("R9 mrs ba1", 10, 1);
    issue(P_MRS, 1, 1, 0);   expect_cmd("R2 emrs", 11, 0);
    issue(P_ACT, 1, 0, 0);   expect_cmd("R10 act in tmrd", 2, 1);

    // R7/R8 sweep over all mode codes
    exp_bl = 2; exp_il = 0; exp_cas = 4;
    for (int cl = 0; cl < 8; cl++)
      for (int bt = 0; bt < 2; bt++)
        for (int bl = 0; bl < 8; bl++) begin
          bit ok;
          ok = (bl >= 1 && bl <= 3) && (cl == 2 || cl == 3 || cl == 6);
          issue(P_MRS, 1, 0, mrs_a(0, 3'(cl), bt[0], 3'(bl)));
          if (ok) begin
            exp_bl = 1 << bl;
            exp_il = bt[0];
            exp_cas = (cl == 2) ? 4 : (cl == 3) ? 6 : 5;
          end
          chk(ok ? "R7 mrs legal" : "R8 mrs reserved", illegal_o, ok ? 0 : 1);
          chk("R7 bl", burst_len_o, exp_bl);
          chk("R7 bt", burst_il_o, exp_il);
          chk("R8 cas", cas_x2_o, exp_cas);
          issue(P_NOP, 1, 0, 0);
        end

    // R10 tMRD window
    issue(P_MRS, 1, 0, mrs_a(0, 3'b011, 1, 3'b010));
    chk("R7 cas6", cas_x2_o, 6);
    issue(P_ACT, 1, 3, 0);   expect_cmd("R10 act blocked", 2, 1);
    issue(P_ACT, 1, 3, 0);   expect_cmd("R10 act after tmrd", 2, 0);
    issue(P_PRE, 1, 3, 0);
    issue(P_NOP, 1, 0, 0);
    issue(P_NOP, 1, 0, 0);
    chk("R5 bank3 idle", bank_state_o, 0);

    // R11 DLL relock window: MRS at edge 0, READ first legal at edge 200
    issue(P_MRS, 1, 0, mrs_a(1, 3'b110, 0, 3'b011));
    expect_cmd("R11 mrs dll", 10, 0);
    chk("R11 dll bit", dll_rst_o, 1);
    chk("R11 lock on", read_lock_o, 1);
    chk("R7 cas5", cas_x2_o, 5);
    issue(P_NOP, 1, 0, 0);                           // edge 1
    issue(P_ACT, 1, 0, 0);   expect_cmd("R11 act ok", 2, 0);   // edge 2
    issue(P_RD, 1, 0, 0);    expect_cmd("R11 read locked", 3, 1); // edge 3
    for (int i = 4; i < 199; i++) issue(P_NOP, 1, 0, 0);
    issue(P_RD, 1, 0, A10);  expect_cmd("R11 reada last locked", 4, 1); // edge 199
    chk("R11 lock off", read_lock_o, 0);
    issue(P_RD, 1, 0, 0);    expect_cmd("R11 read released", 3, 0);   // edge 200

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule